// File: doc/BRIEF.md
# AXI4-Lite to Register Bridge with Clock Crossing

This block is an AXI4-Lite slave that lives in the CPU clock domain. It turns each bus transaction into one access on a simple register port that runs on an unrelated user clock. A write shows up on the register port as a one-cycle write strobe, with a word address, a data word and byte enables. A read shows up as a one-cycle request. The register logic answers it some cycles later with a valid strobe and the data.

The bridge handles one transaction at a time. Write address and write data are captured separately, in either order, and merged. Reads and writes share one register address bus. When both are waiting, the write goes first. A request crosses to the user clock as a toggle through a synchronizer chain, and its fields are held steady while it crosses. The completion comes back the same way, carrying read data where needed. Every AXI channel uses valid/ready. A channel's ready stays low while its captured beat is still waiting to be served, and that is the bridge's only back-pressure towards the master. The response channels hold valid and their payload until the master takes them.

Top module: `axil_reg_bridge`

## Requirements
- R1: Every AXI channel completes a beat only on a cycle where valid and ready are both high. Once BVALID or RVALID rises, it stays high, with RDATA unchanged, until the master's ready accepts it.
- R2: A write-address beat and a write-data beat are each accepted on their own and may arrive in either order, with any gap. No register write is issued until both have arrived.
- R3: Each AXI write produces exactly one user-clock cycle with `reg_wr_en` high. In that cycle `reg_wdata` carries WDATA and `reg_wstrb` carries WSTRB, where bit i qualifies data bits [8i+7:8i].
- R4: `reg_addr` is the AXI byte address divided by four, taken from bits [ADDR_W-1:2]. Bits [1:0] of the byte address are ignored.
- R5: Each AXI read produces exactly one user-clock cycle with `reg_rd_req` high. RVALID rises only after `reg_rd_valid` has been seen, and RDATA equals `reg_rd_data` from that cycle. `reg_rd_valid` is looked at only from the cycle after the request.
- R6: `reg_wr_en` and `reg_rd_req` are never high in the same cycle. At most one of BVALID and RVALID is high at a time.
- R7: When a complete write and a read are both waiting at once, the write is issued first. A read of the same word therefore returns the newly written data.
- R8: BVALID rises only after the write strobe has been issued on the register side.
- R9: BRESP and RRESP are always 2'b00 (OKAY).
- R10: After reset, AWREADY, WREADY and ARREADY are high, and BVALID, RVALID, `reg_wr_en` and `reg_rd_req` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cpu_clk | input | 1 | CPU-side clock (AXI side) |
| cpu_rst_n | input | 1 | Active-low reset, CPU domain |
| usr_clk | input | 1 | User-side clock (register side) |
| usr_rst_n | input | 1 | Active-low reset, user domain |
| s_awaddr | input | ADDR_W | Write address (bytes) |
| s_awvalid | input | 1 | Write address valid |
| s_awready | output | 1 | Write address ready |
| s_wdata | input | DATA_W | Write data |
| s_wstrb | input | DATA_W/8 | Write byte strobes |
| s_wvalid | input | 1 | Write data valid |
| s_wready | output | 1 | Write data ready |
| s_bresp | output | 2 | Write response, always OKAY |
| s_bvalid | output | 1 | Write response valid |
| s_bready | input | 1 | Write response ready |
| s_araddr | input | ADDR_W | Read address (bytes) |
| s_arvalid | input | 1 | Read address valid |
| s_arready | output | 1 | Read address ready |
| s_rdata | output | DATA_W | Read data |
| s_rresp | output | 2 | Read response, always OKAY |
| s_rvalid | output | 1 | Read data valid |
| s_rready | input | 1 | Read data ready |
| reg_addr | output | ADDR_W-2 | Register word address |
| reg_wr_en | output | 1 | One-cycle register write strobe |
| reg_wdata | output | DATA_W | Register write data |
| reg_wstrb | output | DATA_W/8 | Register write byte enables |
| reg_rd_req | output | 1 | One-cycle register read request |
| reg_rd_data | input | DATA_W | Returned register data |
| reg_rd_valid | input | 1 | Returned data valid strobe |

## Verification
The bench builds the bridge with ADDR_W=8, DATA_W=32 and SYNC_STAGES=2. It runs the CPU clock at 10 ns and the user clock at 7 ns, so the two edges drift past each other and every crossing is tried at many phase offsets. The narrow address lets random traffic hit the same 16 words again and again, so read-after-write data is always checked against a shadow copy. Random addresses with nonzero low bits check that the byte offset is dropped. The register model answers reads after 0 to 4 idle cycles and drives junk whenever its valid strobe is low. That shows RDATA is captured exactly in the valid cycle.

// File: rtl/axreg_pkg.sv
package axreg_pkg;
  typedef enum logic [2:0] {
    C_IDLE,
    C_WR_WAIT,
    C_RD_WAIT,
    C_B_RESP,
    C_R_RESP
  } cpu_state_e;

  typedef enum logic {
    U_IDLE,
    U_RD_WAIT
  } usr_state_e;

  localparam logic [1:0] RESP_OKAY = 2'b00;
endpackage

// File: rtl/axreg_sync_bit.sv
module axreg_sync_bit #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/axreg_cpu_side.sv
module axreg_cpu_side
  import axreg_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  localparam int REG_AW = ADDR_W - 2,
  localparam int STRB_W = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] s_awaddr,
  input  logic              s_awvalid,
  output logic              s_awready,
  input  logic [DATA_W-1:0] s_wdata,
  input  logic [STRB_W-1:0] s_wstrb,
  input  logic              s_wvalid,
  output logic              s_wready,
  output logic              s_bvalid,
  input  logic              s_bready,
  input  logic [ADDR_W-1:0] s_araddr,
  input  logic              s_arvalid,
  output logic              s_arready,
  output logic [DATA_W-1:0] s_rdata,
  output logic              s_rvalid,
  input  logic              s_rready,
  output logic              req_tgl,
  output logic              req_is_wr,
  output logic [REG_AW-1:0] req_addr,
  output logic [DATA_W-1:0] req_wdata,
  output logic [STRB_W-1:0] req_strb,
  input  logic              ack_sync,
  input  logic [DATA_W-1:0] ack_rdata
);
  cpu_state_e        state;
  logic              aw_full, w_full, ar_full, ack_seen;
  logic [REG_AW-1:0] aw_addr_q, ar_addr_q;
  logic [DATA_W-1:0] w_data_q;
  logic [STRB_W-1:0] w_strb_q;
  logic              ack_evt;
  logic              unused_low_bits;

  assign unused_low_bits = ^{s_awaddr[1:0], s_araddr[1:0]};
  assign s_awready = !aw_full;
  assign s_wready  = !w_full;
  assign s_arready = !ar_full;
  assign ack_evt   = (ack_sync != ack_seen);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= C_IDLE;
      aw_full   <= 1'b0;
      w_full    <= 1'b0;
      ar_full   <= 1'b0;
      ack_seen  <= 1'b0;
      aw_addr_q <= '0;
      ar_addr_q <= '0;
      w_data_q  <= '0;
      w_strb_q  <= '0;
      req_tgl   <= 1'b0;
      req_is_wr <= 1'b0;
      req_addr  <= '0;
      req_wdata <= '0;
      req_strb  <= '0;
      s_bvalid  <= 1'b0;
      s_rvalid  <= 1'b0;
      s_rdata   <= '0;
    end else begin
      if (s_awvalid && s_awready) begin
        aw_full   <= 1'b1;
        aw_addr_q <= s_awaddr[ADDR_W-1:2];
      end
      if (s_wvalid && s_wready) begin
        w_full   <= 1'b1;
        w_data_q <= s_wdata;
        w_strb_q <= s_wstrb;
      end
      if (s_arvalid && s_arready) begin
        ar_full   <= 1'b1;
        ar_addr_q <= s_araddr[ADDR_W-1:2];
      end
      case (state)
        C_IDLE: begin
          if (aw_full && w_full) begin
            req_is_wr <= 1'b1;
            req_addr  <= aw_addr_q;
            req_wdata <= w_data_q;
            req_strb  <= w_strb_q;
            req_tgl   <= ~req_tgl;
            state     <= C_WR_WAIT;
          end else if (ar_full) begin
            req_is_wr <= 1'b0;
            req_addr  <= ar_addr_q;
            req_tgl   <= ~req_tgl;
            state     <= C_RD_WAIT;
          end
        end
        C_WR_WAIT: if (ack_evt) begin
          ack_seen <= ack_sync;
          aw_full  <= 1'b0;
          w_full   <= 1'b0;
          s_bvalid <= 1'b1;
          state    <= C_B_RESP;
        end
        C_RD_WAIT: if (ack_evt) begin
          ack_seen <= ack_sync;
          ar_full  <= 1'b0;
          s_rdata  <= ack_rdata;
          s_rvalid <= 1'b1;
          state    <= C_R_RESP;
        end
        C_B_RESP: if (s_bready) begin
          s_bvalid <= 1'b0;
          state    <= C_IDLE;
        end
        C_R_RESP: if (s_rready) begin
          s_rvalid <= 1'b0;
          state    <= C_IDLE;
        end
        default: state <= C_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/axreg_usr_side.sv
module axreg_usr_side
  import axreg_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  localparam int REG_AW = ADDR_W - 2,
  localparam int STRB_W = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_sync,
  input  logic              req_is_wr,
  input  logic [REG_AW-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [STRB_W-1:0] req_strb,
  output logic              ack_tgl,
  output logic [DATA_W-1:0] ack_rdata,
  output logic [REG_AW-1:0] reg_addr,
  output logic              reg_wr_en,
  output logic [DATA_W-1:0] reg_wdata,
  output logic [STRB_W-1:0] reg_wstrb,
  output logic              reg_rd_req,
  input  logic [DATA_W-1:0] reg_rd_data,
  input  logic              reg_rd_valid
);
  usr_state_e state;
  logic       req_seen;
  logic       req_evt;

  assign req_evt = (req_sync != req_seen);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= U_IDLE;
      req_seen   <= 1'b0;
      ack_tgl    <= 1'b0;
      ack_rdata  <= '0;
      reg_addr   <= '0;
      reg_wr_en  <= 1'b0;
      reg_wdata  <= '0;
      reg_wstrb  <= '0;
      reg_rd_req <= 1'b0;
    end else begin
      reg_wr_en  <= 1'b0;
      reg_rd_req <= 1'b0;
      case (state)
        U_IDLE: if (req_evt) begin
          req_seen <= req_sync;
          reg_addr <= req_addr;
          if (req_is_wr) begin
            reg_wr_en <= 1'b1;
            reg_wdata <= req_wdata;
            reg_wstrb <= req_strb;
            ack_tgl   <= ~ack_tgl;
          end else begin
            reg_rd_req <= 1'b1;
            state      <= U_RD_WAIT;
          end
        end
        U_RD_WAIT: if (reg_rd_valid) begin
          ack_rdata <= reg_rd_data;
          ack_tgl   <= ~ack_tgl;
          state     <= U_IDLE;
        end
        default: state <= U_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/axil_reg_bridge.sv
module axil_reg_bridge
  import axreg_pkg::*;
#(
  parameter int ADDR_W      = 12,
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2,
  localparam int REG_AW     = ADDR_W - 2,
  localparam int STRB_W     = DATA_W / 8
) (
  input  logic              cpu_clk,
  input  logic              cpu_rst_n,
  input  logic              usr_clk,
  input  logic              usr_rst_n,
  input  logic [ADDR_W-1:0] s_awaddr,
  input  logic              s_awvalid,
  output logic              s_awready,
  input  logic [DATA_W-1:0] s_wdata,
  input  logic [STRB_W-1:0] s_wstrb,
  input  logic              s_wvalid,
  output logic              s_wready,
  output logic [1:0]        s_bresp,
  output logic              s_bvalid,
  input  logic              s_bready,
  input  logic [ADDR_W-1:0] s_araddr,
  input  logic              s_arvalid,
  output logic              s_arready,
  output logic [DATA_W-1:0] s_rdata,
  output logic [1:0]        s_rresp,
  output logic              s_rvalid,
  input  logic              s_rready,
  output logic [REG_AW-1:0] reg_addr,
  output logic              reg_wr_en,
  output logic [DATA_W-1:0] reg_wdata,
  output logic [STRB_W-1:0] reg_wstrb,
  output logic              reg_rd_req,
  input  logic [DATA_W-1:0] reg_rd_data,
  input  logic              reg_rd_valid
);
  logic              req_tgl, req_sync, ack_tgl, ack_sync, req_is_wr;
  logic [REG_AW-1:0] req_addr;
  logic [DATA_W-1:0] req_wdata, ack_rdata;
  logic [STRB_W-1:0] req_strb;

  assign s_bresp = RESP_OKAY;
  assign s_rresp = RESP_OKAY;

  axreg_cpu_side #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cpu (
    .clk(cpu_clk), .rst_n(cpu_rst_n),
    .s_awaddr(s_awaddr), .s_awvalid(s_awvalid), .s_awready(s_awready),
    .s_wdata(s_wdata), .s_wstrb(s_wstrb), .s_wvalid(s_wvalid), .s_wready(s_wready),
    .s_bvalid(s_bvalid), .s_bready(s_bready),
    .s_araddr(s_araddr), .s_arvalid(s_arvalid), .s_arready(s_arready),
    .s_rdata(s_rdata), .s_rvalid(s_rvalid), .s_rready(s_rready),
    .req_tgl(req_tgl), .req_is_wr(req_is_wr), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_strb(req_strb),
    .ack_sync(ack_sync), .ack_rdata(ack_rdata)
  );

  axreg_sync_bit #(.STAGES(SYNC_STAGES)) u_req_sync (
    .clk(usr_clk), .rst_n(usr_rst_n), .d(req_tgl), .q(req_sync)
  );

  axreg_sync_bit #(.STAGES(SYNC_STAGES)) u_ack_sync (
    .clk(cpu_clk), .rst_n(cpu_rst_n), .d(ack_tgl), .q(ack_sync)
  );

  axreg_usr_side #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_usr (
    .clk(usr_clk), .rst_n(usr_rst_n),
    .req_sync(req_sync), .req_is_wr(req_is_wr), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_strb(req_strb),
    .ack_tgl(ack_tgl), .ack_rdata(ack_rdata),
    .reg_addr(reg_addr), .reg_wr_en(reg_wr_en), .reg_wdata(reg_wdata),
    .reg_wstrb(reg_wstrb), .reg_rd_req(reg_rd_req),
    .reg_rd_data(reg_rd_data), .reg_rd_valid(reg_rd_valid)
  );
endmodule

// File: rtl/axil_reg_bridge_chk.sv
module axil_reg_bridge_chk #(
  parameter int DATA_W = 32
) (
  input logic              cpu_clk,
  input logic              cpu_rst_n,
  input logic              usr_clk,
  input logic              usr_rst_n,
  input logic              s_bvalid,
  input logic              s_bready,
  input logic              s_rvalid,
  input logic              s_rready,
  input logic [DATA_W-1:0] s_rdata,
  input logic              reg_wr_en,
  input logic              reg_rd_req
);
  assert_b_hold_R1: assert property (@(posedge cpu_clk) disable iff (!cpu_rst_n)
    s_bvalid && !s_bready |=> s_bvalid);

  assert_r_hold_R1: assert property (@(posedge cpu_clk) disable iff (!cpu_rst_n)
    s_rvalid && !s_rready |=> s_rvalid && $stable(s_rdata));

  assert_wr_pulse_R3: assert property (@(posedge usr_clk) disable iff (!usr_rst_n)
    reg_wr_en |=> !reg_wr_en);

  assert_rd_pulse_R5: assert property (@(posedge usr_clk) disable iff (!usr_rst_n)
    reg_rd_req |=> !reg_rd_req);

  assert_no_overlap_R6: assert property (@(posedge usr_clk) disable iff (!usr_rst_n)
    !(reg_wr_en && reg_rd_req));

  assert_one_resp_R6: assert property (@(posedge cpu_clk) disable iff (!cpu_rst_n)
    !(s_bvalid && s_rvalid));
endmodule

bind axil_reg_bridge axil_reg_bridge_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/sim_axil_reg_bridge.sv
module sim_axil_reg_bridge;
  localparam int AW = 8;
  localparam int DW = 32;

  logic cpu_clk = 0, usr_clk = 0, cpu_rst_n = 0, usr_rst_n = 0;
  always #5 cpu_clk = ~cpu_clk;
  always #3.5 usr_clk = ~usr_clk;

  logic [AW-1:0] s_awaddr = '0, s_araddr = '0;
  logic          s_awvalid = 0, s_wvalid = 0, s_bready = 0, s_arvalid = 0, s_rready = 0;
  logic [DW-1:0] s_wdata = '0;
  logic [3:0]    s_wstrb = '0;
  logic          s_awready, s_wready, s_bvalid, s_arready, s_rvalid;
  logic [1:0]    s_bresp, s_rresp;
  logic [DW-1:0] s_rdata;
  logic [AW-3:0] reg_addr;
  logic          reg_wr_en, reg_rd_req;
  logic [DW-1:0] reg_wdata;
  logic [3:0]    reg_wstrb;
  logic [DW-1:0] reg_rd_data;
  logic          reg_rd_valid;

  axil_reg_bridge #(.ADDR_W(AW), .DATA_W(DW), .SYNC_STAGES(2)) u0 (.*);

  int checks = 0, errors = 0;
  bit done = 0;
  int writes_issued = 0;

  function automatic logic [31:0] merge(input logic [31:0] old, input logic [31:0] nw,
                                        input logic [3:0] st);
    logic [31:0] r = old;
    for (int i = 0; i < 4; i++) if (st[i]) r[8*i +: 8] = nw[8*i +: 8];
    return r;
  endfunction

  // register-side model
  logic [31:0] mem [16];
  int wr_cnt, rdreq_cnt, rdv_cnt, overlap_cnt;
  logic [AW-3:0] last_addr, rd_addr_l;
  logic [31:0] last_data;
  logic [3:0]  last_strb;
  logic pend;
  int dly;

  always @(posedge usr_clk) begin
    if (!usr_rst_n) begin
      for (int i = 0; i < 16; i++) mem[i] <= '0;
      wr_cnt <= 0; rdreq_cnt <= 0; rdv_cnt <= 0; overlap_cnt <= 0;
      pend <= 0; dly <= 0; reg_rd_valid <= 0; reg_rd_data <= 32'hDEAD_BEEF;
      last_addr <= '0; last_data <= '0; last_strb <= '0; rd_addr_l <= '0;
    end else begin
      reg_rd_valid <= 0;
      reg_rd_data  <= 32'hDEAD_BEEF;
      if (reg_wr_en && reg_rd_req) overlap_cnt <= overlap_cnt + 1;
      if (reg_wr_en) begin
        mem[reg_addr[3:0]] <= merge(mem[reg_addr[3:0]], reg_wdata, reg_wstrb);
        wr_cnt <= wr_cnt + 1;
        last_addr <= reg_addr; last_data <= reg_wdata; last_strb <= reg_wstrb;
      end
      if (reg_rd_req) begin
        pend <= 1; rd_addr_l <= reg_addr; dly <= $urandom_range(4, 0);
        rdreq_cnt <= rdreq_cnt + 1;
      end else if (pend) begin
        if (dly == 0) begin
          reg_rd_valid <= 1; reg_rd_data <= mem[rd_addr_l[3:0]];
          pend <= 0; rdv_cnt <= rdv_cnt + 1;
        end else dly <= dly - 1;
      end
    end
  end

  logic [31:0] shadow [16];

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_aw(input logic [AW-1:0] a);
    s_awaddr = a; s_awvalid = 1;
    while (!s_awready) @(negedge cpu_clk);
    @(negedge cpu_clk); s_awvalid = 0;
  endtask

  task automatic do_w(input logic [31:0] d, input logic [3:0] st);
    s_wdata = d; s_wstrb = st; s_wvalid = 1;
    while (!s_wready) @(negedge cpu_clk);
    @(negedge cpu_clk); s_wvalid = 0;
  endtask

  task automatic do_ar(input logic [AW-1:0] a);
    s_araddr = a; s_arvalid = 1;
    while (!s_arready) @(negedge cpu_clk);
    @(negedge cpu_clk); s_arvalid = 0;
  endtask

  task automatic axi_write(input logic [AW-1:0] a, input logic [31:0] d,
                           input logic [3:0] st, input int order, input int bdly);
    int wc0 = wr_cnt;
    case (order)
      0: begin
        do_aw(a); repeat (6) @(negedge cpu_clk);
        chk(wr_cnt == wc0, "R2 no write on address alone", wr_cnt, wc0);
        do_w(d, st);
      end
      1: begin
        do_w(d, st); repeat (6) @(negedge cpu_clk);
        chk(wr_cnt == wc0, "R2 no write on data alone", wr_cnt, wc0);
        do_aw(a);
      end
      default: fork do_aw(a); do_w(d, st); join
    endcase
    shadow[a[5:2]] = merge(shadow[a[5:2]], d, st);
    writes_issued++;
    while (!s_bvalid) @(negedge cpu_clk);
    chk(wr_cnt == wc0 + 1, "R8 write strobe before BVALID", wr_cnt, wc0 + 1);
    chk(s_bresp == 2'b00, "R9 BRESP", s_bresp, 0);
    chk(last_addr == a[AW-1:2], "R4 word address", last_addr, a[AW-1:2]);
    chk(last_data == d && last_strb == st, "R3 data/strobe", {last_strb, last_data[27:0]},
        {st, d[27:0]});
    if (bdly > 0) begin
      repeat (bdly) @(negedge cpu_clk);
      chk(s_bvalid, "R1 BVALID held", s_bvalid, 1);
    end
    s_bready = 1; @(negedge cpu_clk); s_bready = 0;
    chk(!s_bvalid, "R1 BVALID dropped after accept", s_bvalid, 0);
  endtask

  task automatic axi_read(input logic [AW-1:0] a, input int rdly);
    int rq0 = rdreq_cnt, rv0 = rdv_cnt;
    logic [31:0] held;
    do_ar(a);
    while (!s_rvalid) @(negedge cpu_clk);
    chk(rdreq_cnt == rq0 + 1 && rdv_cnt == rv0 + 1, "R5 one request, valid seen",
        rdv_cnt, rv0 + 1);
    chk(s_rdata == shadow[a[5:2]], "R5 read data", s_rdata, shadow[a[5:2]]);
    chk(s_rresp == 2'b00, "R9 RRESP", s_rresp, 0);
    held = s_rdata;
    if (rdly > 0) begin
      repeat (rdly) @(negedge cpu_clk);
      chk(s_rvalid && s_rdata == held, "R1 RVALID/RDATA held", s_rdata, held);
    end
    s_rready = 1; @(negedge cpu_clk); s_rready = 0;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed));
    for (int i = 0; i < 16; i++) shadow[i] = '0;
    repeat (4) @(negedge cpu_clk);
    cpu_rst_n = 1; usr_rst_n = 1;
    @(negedge cpu_clk);
    // R10 reset state
    chk(s_awready && s_wready && s_arready, "R10 readies after reset",
        {s_awready, s_wready, s_arready}, 3'b111);
    chk(!s_bvalid && !s_rvalid && !reg_wr_en && !reg_rd_req, "R10 idle after reset",
        {s_bvalid, s_rvalid, reg_wr_en, reg_rd_req}, 0);

    // directed: both orders, low byte-address bits ignored (R4), partial strobes
    axi_write(8'h13, 32'h1122_3344, 4'hF, 0, 0);
    axi_write(8'h16, 32'hAABB_CCDD, 4'b0101, 1, 3);
    axi_write(8'h10, 32'h5566_7788, 4'b1000, 2, 0);
    axi_read(8'h12, 4);
    axi_read(8'h14, 0);

    // R7: write and read to same word pending together
    begin
      logic [31:0] nv;
      nv = merge(shadow[5], 32'hCAFE_F00D, 4'hF);
      fork do_aw(8'h14); do_w(32'hCAFE_F00D, 4'hF); do_ar(8'h14); join
      shadow[5] = nv; writes_issued++;
      while (!s_bvalid && !s_rvalid) @(negedge cpu_clk);
      chk(s_bvalid && !s_rvalid, "R7 write served first", {s_bvalid, s_rvalid}, 2'b10);
      s_bready = 1; @(negedge cpu_clk); s_bready = 0;
      while (!s_rvalid) @(negedge cpu_clk);
      chk(s_rdata == nv, "R7 read sees new data", s_rdata, nv);
      s_rready = 1; @(negedge cpu_clk); s_rready = 0;
    end

    // random traffic
    for (int n = 0; n < 80; n++) begin
      logic [AW-1:0] a;
      a = {2'b00, 4'($urandom_range(15, 0)), 2'($urandom_range(3, 0))};
      if ($urandom_range(1, 0) == 1)
        axi_write(a, $urandom, 4'($urandom_range(15, 0)), $urandom_range(2, 0),
                  $urandom_range(3, 0));
      else
        axi_read(a, $urandom_range(3, 0));
    end

    repeat (10) @(negedge cpu_clk);
    chk(wr_cnt == writes_issued, "R3 one strobe per write", wr_cnt, writes_issued);
    chk(overlap_cnt == 0, "R6 no write/read overlap", overlap_cnt, 0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule